// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block sits between a serial transmitter and an output pin and turns the transmit bit stream into a drive signal for an infrared emitter. Two carrier waveforms come in from timer outputs generated elsewhere. The block keys them with a data bit. In amplitude-shift keying, the first carrier is gated on and off. In frequency-shift keying, the block switches between the first and the second carrier.

Software programs a five-bit control register with a single write strobe. The register holds a function enable, a polarity inversion, the keying mode, the data source and a software data bit. The data source is either the live serial line or the register's own data bit. The keying path after the register is purely combinational, so carrier edges reach the pin without delay. A control write takes effect on the clock edge that captures it.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset is applied, every control bit is 0, so `ir_pin` equals `ser_tx`.
- R2: While the enable bit (control bit 0) is 0, `ir_pin` equals `ser_tx`, whatever the other control bits, the carriers and the source selection hold.
- R3: The effective data is the selected source XORed with the polarity bit (control bit 1). The source is `ser_tx` when the source bit (control bit 3) is 0, and the software data bit (control bit 4) when it is 1.
- R4: With enable at 1 and the mode bit (control bit 2) at 0, `ir_pin` equals `car_a` while the effective data is 1, and is 0 while the effective data is 0.
- R5: With enable at 1 and the mode bit at 1, `ir_pin` equals `car_a` while the effective data is 1, and equals `car_b` while it is 0.
- R6: When `ctrl_we` is 1 at a rising clock edge, `ctrl_wdata` is captured, and it governs `ir_pin` from that edge on. Before that edge the previous value still applies. When `ctrl_we` is 0, the control value is held.
- R7: A change on `car_a`, `car_b` or `ser_tx` reaches `ir_pin` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control word: bit0 enable, bit1 invert, bit2 FSK, bit3 register source, bit4 data |
| car_a | input | 1 | First carrier (mark carrier) |
| car_b | input | 1 | Second carrier (space carrier, FSK only) |
| ser_tx | input | 1 | Serial transmit data |
| ir_pin | output | 1 | Modulated or bypassed pin drive |

## Verification
The bench builds the block with its default control width of five bits. That width lets it sweep all 32 control words. Each control word is followed by all eight combinations of the serial line and the two carriers, so every mode, polarity and source pairing is covered. Each write cycle is also checked against the control value that was in force before the write, which covers the one-edge latency.

// File: rtl/irm_pkg.sv
package irm_pkg;
    typedef struct packed {
        logic data_bit;   // bit 4
        logic src_reg;    // bit 3
        logic fsk;        // bit 2
        logic pol_inv;    // bit 1
        logic enable;     // bit 0
    } irm_ctrl_t;

    localparam int CTRL_W = $bits(irm_ctrl_t);
endpackage

// File: rtl/irm_ctrl_reg.sv
module irm_ctrl_reg
    import irm_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output irm_ctrl_t     ctrl
);
    typedef struct packed {
        irm_ctrl_t ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.ctrl = irm_ctrl_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // R6: a write is seen exactly one edge later; no write holds the value
    a_r6_write_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> (ctrl == irm_ctrl_t'($past(wdata))));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we) |-> $stable(ctrl));
endmodule

// File: rtl/irm_data_sel.sv
module irm_data_sel
    import irm_pkg::*;
(
    input  irm_ctrl_t ctrl,
    input  logic      ser_tx,
    output logic      eff_data
);
    logic raw;

    always_comb begin
        raw      = ctrl.src_reg ? ctrl.data_bit : ser_tx;
        eff_data = raw ^ ctrl.pol_inv;
    end
endmodule

// File: rtl/irm_keyer.sv
module irm_keyer
    import irm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  irm_ctrl_t ctrl,
    input  logic      eff_data,
    input  logic      car_a,
    input  logic      car_b,
    input  logic      ser_tx,
    output logic      pin
);
    logic keyed;

    always_comb begin
        if (ctrl.fsk) keyed = eff_data ? car_a : car_b;
        else          keyed = eff_data & car_a;
        pin = ctrl.enable ? keyed : ser_tx;
    end

    // R2: disabled path is transparent to serial data
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.enable |-> (pin == ser_tx));
    // R4: ASK space is silent
    a_r4_ask_space_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && !ctrl.fsk && !eff_data) |-> !pin);
    // R4 / R5: mark always follows the first carrier
    a_r5_mark_car_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && eff_data) |-> (pin == car_a));
    // R5: FSK space follows the second carrier
    a_r5_fsk_space_car_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && ctrl.fsk && !eff_data) |-> (pin == car_b));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
    import irm_pkg::*;
#(
    parameter int CTRL_BITS = CTRL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  logic [CTRL_BITS-1:0] ctrl_wdata,
    input  logic                 car_a,
    input  logic                 car_b,
    input  logic                 ser_tx,
    output logic                 ir_pin
);
    irm_ctrl_t ctrl;
    logic      eff_data;

    irm_ctrl_reg #(.W(CTRL_BITS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl)
    );

    irm_data_sel u_sel (
        .ctrl     (ctrl),
        .ser_tx   (ser_tx),
        .eff_data (eff_data)
    );

    irm_keyer u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .eff_data (eff_data),
        .car_a    (car_a),
        .car_b    (car_b),
        .ser_tx   (ser_tx),
        .pin      (ir_pin)
    );

    // R3: register source with enable and mark forces first carrier
    a_r3_reg_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && ctrl.src_reg && (ctrl.data_bit != ctrl.pol_inv)) |-> (ir_pin == car_a));
endmodule

// File: tb/sim_ir_carrier_mod.sv
module sim_ir_carrier_mod;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic       car_a = 1'b0, car_b = 1'b0, ser_tx = 1'b0;
    logic       ir_pin;

    int checks = 0;
    int fails  = 0;
    int model_ctrl = 0;   // reference copy of control word

    always #2 clk = ~clk;   // 250 MHz

    ir_carrier_mod u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .car_a(car_a), .car_b(car_b), .ser_tx(ser_tx), .ir_pin(ir_pin)
    );

    function automatic bit ref_out(int c, bit tx, bit ca, bit cb);
        bit en, inv, fsk, srcr, db, eff;
        en = c[0]; inv = c[1]; fsk = c[2]; srcr = c[3]; db = c[4];
        eff = (srcr ? db : tx) ^ inv;       // R3
        if (!en) return tx;                 // R2
        if (fsk) return eff ? ca : cb;      // R5
        return eff & ca;                    // R4
    endfunction

    task automatic check(bit exp, string tag);
        checks++;
        if (ir_pin !== exp) begin
            fails++;
            $display("FAIL %s ctrl=%0h tx=%0b a=%0b b=%0b actual=%0b expected=%0b",
                     tag, model_ctrl, ser_tx, car_a, car_b, ir_pin, exp);
        end
    endtask

    // Drive at falling edge, check shortly after, update model at rising edge
    task automatic step(bit we, int wd, bit tx, bit ca, bit cb);
        string tag;
        @(negedge clk);
        ctrl_we = we; ctrl_wdata = wd[4:0];
        ser_tx = tx; car_a = ca; car_b = cb;
        #1;
        if (we)              tag = "R6";
        else if (!model_ctrl[0]) tag = "R2";
        else if (model_ctrl[2])  tag = "R5 R3 R7";
        else                     tag = "R4 R3 R7";
        check(ref_out(model_ctrl, tx, ca, cb), tag);
        @(posedge clk);
        if (we) model_ctrl = wd;
        #0;
    endtask

    initial begin
        fork
            begin
                repeat (5) @(posedge clk);
                rst_n = 1'b1;
                // R1: reset state passes serial data
                @(negedge clk); ser_tx = 1'b1; car_a = 1'b1; #1;
                check(1'b1, "R1");
                ser_tx = 1'b0; #1;
                check(1'b0, "R1");
                for (int c = 0; c < 32; c++) begin
                    step(1'b1, c, c[0], ~c[1], c[2]);
                    for (int v = 0; v < 8; v++)
                        step(1'b0, 0, v[0], v[1], v[2]);
                end
                // R7: carrier toggles within one cycle, FSK, serial source
                step(1'b1, 5'b00101, 1'b0, 1'b0, 1'b0);
                @(negedge clk); ser_tx = 1'b1; car_a = 1'b1; #1;
                check(1'b1, "R7");
                car_a = 1'b0; #0.5;
                check(1'b0, "R7");
            end
            begin
                repeat (20000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule